// File: doc/BRIEF.md
# PUF Response Reliability Statistics Unit

This block collects raw statistics on how stable the responses of a physical unclonable function are once a challenge filter has picked which challenges to keep. Each offered challenge arrives as one strobe that says whether the filter kept it. A kept challenge carries its reference response, taken once at the nominal operating condition, and a programmable number of re-evaluations that follow. Each later re-evaluated bit is compared with that stored reference. A mismatch is one error.

Six saturating counters hold the statistics: errors, evaluations, offered challenges, accepted challenges, discarded challenges and accepted references equal to 1. Firmware reads them through a small read port with one cycle of latency. From these counts it works out the error rate, the filter loss and the response bias. The block does no division. A sticky flag records re-evaluated bits that arrive when no reference is held.

A two-state controller tracks each challenge. In `WAIT_REF` no reference is held. In `COLLECT` a reference is held and evaluations remain. The transitions are as follows:
- ACCEPT goes from `WAIT_REF` to `COLLECT` on a kept challenge with a nonzero count.
- RELOAD goes from `COLLECT` to `COLLECT` on a new kept challenge.
- LAST_EVAL goes from `COLLECT` to `WAIT_REF` on the final expected evaluation.
- ZERO_LOAD goes to `WAIT_REF` on a kept challenge with a count of 0.
- CLEAR goes from any state to `WAIT_REF`.

Top module: `puf_rel_stats`

## Requirements
- R1: Reset and the synchronous clear input set every counter to 0, clear the protocol flag and return the controller to WAIT_REF in one cycle. Clear has priority over any strobe in the same cycle.
- R2: A challenge strobe with pass=1 adds 1 to the offered and accepted counters. It also adds 1 to the ones counter when the reference bit is 1. The reference bit and the evaluation count are latched.
- R3: A challenge strobe with pass=0 adds 1 to the offered and discarded counters and leaves the controller state unchanged.
- R4: Every evaluation strobe in COLLECT adds 1 to the evaluation counter. It also adds 1 to the error counter when the evaluated bit differs from the latched reference.
- R5: After the latched number of evaluations the controller returns to WAIT_REF. A further evaluation is then not counted and sets the protocol flag.
- R6: An evaluation strobe in WAIT_REF is ignored and sets the sticky protocol flag. This includes a strobe in the same cycle as the reference. The flag stays set until reset or clear.
- R7: The evaluation count is programmable from 1 to 255, which covers 100 and 128. A count of 0 leaves the controller in WAIT_REF.
- R8: Counters saturate at all ones instead of wrapping.
- R9: Read addresses are: 0 errors, 1 evaluations, 2 offered, 3 accepted, 4 discarded, 5 ones, 6 status. In the status word, bit 0 is the protocol flag and bit 1 means COLLECT. Address 7 reads 0. Read data appears one clock after the address.
- R10: A pass=1 strobe in COLLECT replaces the reference and restarts the count, abandoning the rest of the previous challenge without setting the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics |
| chal_valid | input | 1 | Challenge offered this cycle |
| chal_pass | input | 1 | Challenge kept by the filter |
| chal_ref | input | 1 | Reference response of a kept challenge |
| eval_count | input | 8 | Number of re-evaluations of a kept challenge |
| eval_valid | input | 1 | Re-evaluated bit present |
| eval_bit | input | 1 | Re-evaluated response bit |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| proto_err | output | 1 | Sticky protocol flag |

## Verification
Challenge and evaluation strobes sampled at one rising edge are visible in the counters after that edge. A read returns data on the edge after its address is presented, so any result read back is due two edges after its stimulus. The bench drives every input on a falling edge and holds each read address across exactly one rising edge. It samples read data on the next falling edge, so every stimulus has already reached the counters before the read. A second instance with narrow counters receives the same stimulus, and its expected values are the full expected counts clipped at its maximum.

// File: rtl/puf_rel_stats_pkg.sv
package puf_rel_stats_pkg;

    localparam int ADDR_W  = 3;
    localparam int NUM_CNT = 6;

    localparam int IDX_ERR  = 0;
    localparam int IDX_EVAL = 1;
    localparam int IDX_OFF  = 2;
    localparam int IDX_ACC  = 3;
    localparam int IDX_DIS  = 4;
    localparam int IDX_ONE  = 5;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd6;
    localparam logic [ADDR_W-1:0] ADDR_NONE   = 3'd7;

    typedef enum logic {
        WAIT_REF = 1'b0,
        COLLECT  = 1'b1
    } trk_state_t;

endpackage

// File: rtl/rel_sat_counter.sv
module rel_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX && !clr) |=> (cnt == MAX));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt >= $past(cnt)));

    // R1
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/rel_chal_tracker.sv
module rel_chal_tracker
    import puf_rel_stats_pkg::*;
#(
    parameter int EVAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              chal_valid,
    input  logic              chal_pass,
    input  logic              chal_ref,
    input  logic [EVAL_W-1:0] eval_count,
    input  logic              eval_valid,
    input  logic              eval_bit,
    output logic              inc_err,
    output logic              inc_eval,
    output logic              inc_off,
    output logic              inc_acc,
    output logic              inc_dis,
    output logic              inc_one,
    output logic              collecting,
    output logic              proto_err
);
    trk_state_t        state_q, state_d;
    logic [EVAL_W-1:0] left_q, left_d;
    logic              ref_q, ref_d;
    logic              flag_q;
    logic              kept;
    logic              eval_ok;
    logic              stray;

    assign kept = chal_valid && chal_pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WAIT_REF;
            left_q  <= '0;
            ref_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            ref_q   <= ref_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        ref_d   = ref_q;
        if (clr) begin
            state_d = WAIT_REF;
            left_d  = '0;
        end else if (kept) begin
            ref_d   = chal_ref;
            left_d  = eval_count;
            state_d = (eval_count != '0) ? COLLECT : WAIT_REF;
        end else begin
            unique case (state_q)
                WAIT_REF: begin
                    state_d = WAIT_REF;
                end
                COLLECT: begin
                    if (eval_valid) begin
                        left_d = left_q - 1'b1;
                        if (left_q == {{(EVAL_W-1){1'b0}}, 1'b1}) begin
                            state_d = WAIT_REF;
                        end
                    end
                end
                default: state_d = WAIT_REF;
            endcase
        end
    end

    always_comb begin
        inc_off  = 1'b0;
        inc_acc  = 1'b0;
        inc_dis  = 1'b0;
        inc_one  = 1'b0;
        eval_ok  = 1'b0;
        stray    = 1'b0;
        if (!clr) begin
            inc_off = chal_valid;
            inc_acc = kept;
            inc_dis = chal_valid && !chal_pass;
            inc_one = kept && chal_ref;
            unique case (state_q)
                WAIT_REF: stray   = eval_valid;
                COLLECT:  eval_ok = eval_valid;
                default:  stray   = eval_valid;
            endcase
        end
        inc_eval   = eval_ok;
        inc_err    = eval_ok && (eval_bit != ref_q);
        collecting = (state_q == COLLECT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (clr) begin
            flag_q <= 1'b0;
        end else if (stray) begin
            flag_q <= 1'b1;
        end
    end

    assign proto_err = flag_q;

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);

    // R6
    wait_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WAIT_REF && eval_valid && !clr) |=> flag_q);

    // R5
    collect_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == COLLECT) |-> (left_q != '0));

    // R10
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kept && !clr && eval_count != '0) |=>
            (state_q == COLLECT && left_q == $past(eval_count)));

endmodule

// File: rtl/rel_readback.sv
module rel_readback
    import puf_rel_stats_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [NUM_CNT-1:0][COUNT_W-1:0]  cnt_bus,
    input  logic                             collecting,
    input  logic                             proto_err,
    output logic [COUNT_W-1:0]               rd_data
);
    logic [COUNT_W-1:0] sel;
    logic [COUNT_W-1:0] status_w;

    assign status_w = {{(COUNT_W-2){1'b0}}, collecting, proto_err};

    always_comb begin
        if (rd_addr < ADDR_W'(NUM_CNT)) begin
            sel = cnt_bus[rd_addr];
        end else if (rd_addr == ADDR_STATUS) begin
            sel = status_w;
        end else begin
            sel = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= sel;
        end
    end

    // R9
    rd_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_NONE) |=> (rd_data == '0));

endmodule

// File: rtl/puf_rel_stats.sv
module puf_rel_stats
    import puf_rel_stats_pkg::*;
#(
    parameter int COUNT_W = 32,
    parameter int EVAL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               chal_valid,
    input  logic               chal_pass,
    input  logic               chal_ref,
    input  logic [EVAL_W-1:0]  eval_count,
    input  logic               eval_valid,
    input  logic               eval_bit,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [COUNT_W-1:0] rd_data,
    output logic               proto_err
);
    logic [NUM_CNT-1:0]              inc_vec;
    logic [NUM_CNT-1:0][COUNT_W-1:0] cnt_bus;
    logic                            collecting;

    rel_chal_tracker #(.EVAL_W(EVAL_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .chal_valid (chal_valid),
        .chal_pass  (chal_pass),
        .chal_ref   (chal_ref),
        .eval_count (eval_count),
        .eval_valid (eval_valid),
        .eval_bit   (eval_bit),
        .inc_err    (inc_vec[IDX_ERR]),
        .inc_eval   (inc_vec[IDX_EVAL]),
        .inc_off    (inc_vec[IDX_OFF]),
        .inc_acc    (inc_vec[IDX_ACC]),
        .inc_dis    (inc_vec[IDX_DIS]),
        .inc_one    (inc_vec[IDX_ONE]),
        .collecting (collecting),
        .proto_err  (proto_err)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        rel_sat_counter #(.W(COUNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc_vec[g]),
            .cnt   (cnt_bus[g])
        );
    end

    rel_readback #(.COUNT_W(COUNT_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .cnt_bus    (cnt_bus),
        .collecting (collecting),
        .proto_err  (proto_err),
        .rd_data    (rd_data)
    );

    // R4
    err_le_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_bus[IDX_ERR] <= cnt_bus[IDX_EVAL]);

endmodule

// File: tb/tb_puf_rel_stats.sv
module tb_puf_rel_stats;
    localparam int SAT_W   = 6;
    localparam int SAT_MAX = (1 << SAT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        chal_valid = 1'b0;
    logic        chal_pass = 1'b0;
    logic        chal_ref = 1'b0;
    logic [7:0]  eval_count = 8'd0;
    logic        eval_valid = 1'b0;
    logic        eval_bit = 1'b0;
    logic [2:0]  rd_addr = 3'd0;
    logic [31:0] rd_data;
    logic [SAT_W-1:0] rd_data_s;
    logic        proto_err, proto_err_s;

    int nchk = 0;
    int nfail = 0;

    longint e [6];
    logic   exp_busy = 1'b0;
    logic   exp_flag = 1'b0;
    logic   exp_ref = 1'b0;
    int     exp_left = 0;

    // {pass, ref, count[7:0], pattern[15:0]}
    localparam logic [25:0] VEC [8] = '{
        {1'b1, 1'b0, 8'd4,  16'h0000},
        {1'b1, 1'b1, 8'd4,  16'h000B},
        {1'b0, 1'b0, 8'd0,  16'h0000},
        {1'b1, 1'b1, 8'd16, 16'hFFFF},
        {1'b1, 1'b0, 8'd8,  16'h00A5},
        {1'b0, 1'b1, 8'd0,  16'h0000},
        {1'b1, 1'b1, 8'd1,  16'h0000},
        {1'b1, 1'b0, 8'd3,  16'h0007}
    };

    always #5 clk = ~clk;

    puf_rel_stats dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .chal_valid(chal_valid), .chal_pass(chal_pass), .chal_ref(chal_ref),
        .eval_count(eval_count), .eval_valid(eval_valid), .eval_bit(eval_bit),
        .rd_addr(rd_addr), .rd_data(rd_data), .proto_err(proto_err)
    );

    puf_rel_stats #(.COUNT_W(SAT_W)) dut_sat (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .chal_valid(chal_valid), .chal_pass(chal_pass), .chal_ref(chal_ref),
        .eval_count(eval_count), .eval_valid(eval_valid), .eval_bit(eval_bit),
        .rd_addr(rd_addr), .rd_data(rd_data_s), .proto_err(proto_err_s)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint clip(input longint v);
        return (v > SAT_MAX) ? SAT_MAX : v;
    endfunction

    function automatic string tag_of(input int a);
        if (a < 2) return "R4";
        if (a == 4) return "R3";
        return "R2";
    endfunction

    task automatic rd(input int a, output longint v, output longint vs);
        @(negedge clk);
        rd_addr = 3'(a);
        @(negedge clk);
        v  = rd_data;
        vs = rd_data_s;
    endtask

    task automatic check_all(input string ctx);
        longint v, vs;
        for (int a = 0; a < 6; a++) begin
            rd(a, v, vs);
            chk(tag_of(a), $sformatf("%s counter %0d", ctx, a), v, e[a]);
            chk("R8", $sformatf("%s narrow counter %0d", ctx, a), vs, clip(e[a]));
        end
        rd(6, v, vs);
        chk("R9", $sformatf("%s status", ctx), v, {exp_busy, exp_flag});
    endtask

    task automatic model_clear();
        for (int a = 0; a < 6; a++) e[a] = 0;
        exp_busy = 1'b0;
        exp_flag = 1'b0;
        exp_left = 0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
    endtask

    task automatic offer(input logic p, input logic r, input int n);
        @(negedge clk);
        chal_valid = 1'b1;
        chal_pass  = p;
        chal_ref   = r;
        eval_count = 8'(n);
        @(negedge clk);
        chal_valid = 1'b0;
        e[2]++;
        if (p) begin
            e[3]++;
            if (r) e[5]++;
            exp_ref  = r;
            exp_left = n;
            exp_busy = (n != 0);
        end else begin
            e[4]++;
        end
    endtask

    task automatic ev(input logic b);
        @(negedge clk);
        eval_valid = 1'b1;
        eval_bit   = b;
        @(negedge clk);
        eval_valid = 1'b0;
        if (exp_busy) begin
            e[1]++;
            if (b != exp_ref) e[0]++;
            exp_left--;
            if (exp_left == 0) exp_busy = 1'b0;
        end else begin
            exp_flag = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        longint v, vs;
        logic [25:0] vec;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_all("R1 after reset");
        chk("R1", "flag port after reset", proto_err, 0);

        // Table of challenges: R2 R3 R4 R5
        for (int k = 0; k < 8; k++) begin
            vec = VEC[k];
            offer(vec[25], vec[24], int'(vec[23:16]));
            if (vec[25]) begin
                for (int i = 0; i < int'(vec[23:16]); i++) ev(vec[i]);
            end
            check_all($sformatf("vector %0d", k));
        end

        // R9 unused address reads zero
        rd(7, v, vs);
        chk("R9", "address 7", v, 0);

        // R7 count of zero keeps WAIT_REF; the following evaluation is stray
        offer(1'b1, 1'b1, 0);
        ev(1'b0);
        check_all("R7 zero count");
        chk("R6", "flag port after stray", proto_err, 1);

        // R6 flag stays set across normal traffic
        offer(1'b1, 1'b0, 2);
        ev(1'b0);
        ev(1'b1);
        check_all("R6 sticky");

        // R1 clear has priority over a strobe in the same cycle
        @(negedge clk);
        clr = 1'b1;
        chal_valid = 1'b1;
        chal_pass  = 1'b1;
        chal_ref   = 1'b1;
        eval_count = 8'd3;
        @(negedge clk);
        clr = 1'b0;
        chal_valid = 1'b0;
        model_clear();
        check_all("R1 clear");

        // R7 count of 100, all mismatching; R8 narrow counters clip
        offer(1'b1, 1'b0, 100);
        for (int i = 0; i < 100; i++) ev(1'b1);
        check_all("R7 count 100");
        // R5 one evaluation beyond the count
        ev(1'b1);
        check_all("R5 overrun");

        // R7 count of 128, alternating bits against reference 1
        do_clear();
        offer(1'b1, 1'b1, 128);
        for (int i = 0; i < 128; i++) ev(i[0]);
        check_all("R7 count 128");

        // R10 reload in COLLECT
        do_clear();
        offer(1'b1, 1'b1, 5);
        ev(1'b0);
        ev(1'b0);
        offer(1'b1, 1'b0, 3);
        ev(1'b0);
        ev(1'b0);
        check_all("R10 mid reload");
        ev(1'b0);
        check_all("R10 after reload");

        // R6 evaluation in the same cycle as the reference is ignored
        do_clear();
        @(negedge clk);
        chal_valid = 1'b1;
        chal_pass  = 1'b1;
        chal_ref   = 1'b1;
        eval_count = 8'd2;
        eval_valid = 1'b1;
        eval_bit   = 1'b0;
        @(negedge clk);
        chal_valid = 1'b0;
        eval_valid = 1'b0;
        e[2] = 1; e[3] = 1; e[5] = 1;
        exp_ref = 1'b1; exp_left = 2; exp_busy = 1'b1; exp_flag = 1'b1;
        check_all("R6 same cycle");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule